// File: doc/BRIEF.md
# Successive Approximation ADC Sequencer

This block is the digital half of an 8-bit successive-approximation converter that serves six multiplexed analog inputs. A host writes one control byte that picks an input, chooses the conversion clock rate and, optionally, launches a conversion. The sequencer holds the selected input on its channel-select output, opens a sample window, and then tests the result bits one at a time, from the most significant down. For each test it offers a trial code to the external ladder and reads back a single comparator bit.

Each conversion has a fixed length, counted in ticks of a conversion clock. That clock runs at the system rate or at half of it. When the last tick ends, the 8-bit code goes to the result output. At that moment a done flag sets and a one-cycle interrupt pulse fires. Done stays set until the host reads the result or starts another conversion.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, busy, done and irq are 0, result is 00h, chan_sel is 0 and sample_en is 0.
- R2: A control write accepted while idle loads the channel from bits [2:0] and the clock select from bit 6. A channel value above 5 is stored as 5. Setting bit 7 in the same write starts a conversion.
- R3: After a start, busy is high for exactly 26 conversion-clock ticks. That is 26 system cycles with clock select 0 and 52 cycles with clock select 1.
- R4: For the first 6 ticks after the start (6 or 12 system cycles), sample_en is high and trial_code is 00h. No cycle outside this window has sample_en high.
- R5: Bits are decided MSB first, one per tick. A trial bit is kept when cmp_in is 1 (input at or above the trial code) and cleared otherwise. With a monotonic comparator, result equals the input code for every value from 00h to FFh.
- R6: result changes only in the cycle in which irq is high, so it holds its old value for the whole conversion.
- R7: A control write while busy has no effect. It does not restart the conversion, does not lengthen it, and changes neither the channel nor the clock select.
- R8: done rises in the same cycle that busy falls and the new result appears. irq is high for exactly that one cycle.
- R9: done clears in the cycle after a res_rd pulse, and in the cycle after an accepted start.
- R10: chan_sel stays constant while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [2:0] channel, [6] half-rate clock, [7] start |
| res_rd | input | 1 | Host read of the result; clears done |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above trial_code |
| chan_sel | output | 3 | Analog input selection, 0 to 5 |
| sample_en | output | 1 | Sample-and-hold window |
| trial_code | output | 8 | Code applied to the ladder |
| result | output | 8 | Last converted code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result valid and not yet read |
| irq | output | 1 | One-cycle interrupt request when a result lands |

## Verification
The assertions assume that cmp_in is a function of trial_code and of the input selected by chan_sel, and that it settles within the same cycle. They also assume that the host writes the control byte as single-cycle strobes. The bench models the comparator as a combinational compare of per-channel input codes against trial_code, so cmp_in follows trial_code in the same cycle and stays monotonic. Strobes are driven at falling edges for one cycle only, including the deliberate writes made in the middle of a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CTL_START_BIT = 7;
  localparam int CTL_HALF_BIT  = 6;
  localparam int CTL_W         = 8;
endpackage

// File: rtl/sar_ce_gen.sv
module sar_ce_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  input  logic half_rate,
  output logic ce
);
  logic div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (start)     div_d = 1'b0;
    else if (busy) div_d = ~div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= div_d;
  end

  assign ce = busy & (half_rate ? div_q : 1'b1);
endmodule

// File: rtl/sar_timeline.sv
module sar_timeline #(
  parameter int TOTAL  = 26,
  parameter int SAMPLE = 6,
  parameter int RES_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     busy,
  input  logic                     ce,
  output logic                     in_sample,
  output logic                     in_decide,
  output logic [$clog2(RES_W)-1:0] dec_bit,
  output logic                     last_tick
);
  localparam int CW = $clog2(TOTAL);
  localparam int BW = $clog2(RES_W);
  localparam logic [CW-1:0] SAMPLE_C = CW'(SAMPLE);
  localparam logic [CW-1:0] DEC_END  = CW'(SAMPLE + RES_W);
  localparam logic [CW-1:0] LAST_C   = CW'(TOTAL - 1);
  localparam logic [BW-1:0] TOP_BIT  = BW'(RES_W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] dec_off;

  always_comb begin
    cnt_d = cnt_q;
    if (start)   cnt_d = '0;
    else if (ce) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dec_off   = cnt_q - SAMPLE_C;
  assign in_sample = busy && (cnt_q < SAMPLE_C);
  assign in_decide = busy && (cnt_q >= SAMPLE_C) && (cnt_q < DEC_END);
  assign dec_bit   = TOP_BIT - dec_off[BW-1:0];
  assign last_tick = ce && (cnt_q == LAST_C);
endmodule

// File: rtl/sar_decide.sv
module sar_decide #(
  parameter int RES_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     ce,
  input  logic                     in_decide,
  input  logic [$clog2(RES_W)-1:0] dec_bit,
  input  logic                     last_tick,
  input  logic                     cmp_in,
  output logic [RES_W-1:0]         trial_code,
  output logic [RES_W-1:0]         result
);
  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] mask;

  always_comb begin
    mask = '0;
    mask[dec_bit] = 1'b1;
  end

  always_comb begin
    sar_d = sar_q;
    if (start) sar_d = '0;
    else if (ce && in_decide) sar_d[dec_bit] = cmp_in;
  end

  always_comb begin
    res_d = res_q;
    if (last_tick) res_d = sar_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      sar_q <= sar_d;
      res_q <= res_d;
    end
  end

  assign trial_code = in_decide ? (sar_q | mask) : sar_q & {RES_W{~in_decide}} & '0;
  assign result     = res_q;
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W  = 8,
  parameter int N_CH   = 6,
  parameter int SAMPLE = 6,
  parameter int TOTAL  = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_wr,
  input  logic [7:0]              ctl_wdata,
  input  logic                    res_rd,
  input  logic                    cmp_in,
  output logic [$clog2(N_CH)-1:0] chan_sel,
  output logic                    sample_en,
  output logic [RES_W-1:0]        trial_code,
  output logic [RES_W-1:0]        result,
  output logic                    busy,
  output logic                    done,
  output logic                    irq
);
  import sar_pkg::*;
  localparam int CH_W = $clog2(N_CH);
  localparam int BW   = $clog2(RES_W);
  localparam logic [CH_W-1:0] CH_MAX = CH_W'(N_CH - 1);

  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic            irq_q;
  logic            clksel_q, clksel_d;
  logic [CH_W-1:0] ch_q, ch_d, ch_in;
  logic            cfg_wr, start;
  logic            ce, in_sample, in_decide, last_tick;
  logic [BW-1:0]   dec_bit;

  assign cfg_wr = ctl_wr & ~busy_q;
  assign start  = cfg_wr & ctl_wdata[CTL_START_BIT];
  assign ch_in  = (ctl_wdata[CH_W-1:0] > CH_MAX) ? CH_MAX : ctl_wdata[CH_W-1:0];

  always_comb begin
    ch_d     = ch_q;
    clksel_d = clksel_q;
    busy_d   = busy_q;
    done_d   = done_q;
    if (cfg_wr) begin
      ch_d     = ch_in;
      clksel_d = ctl_wdata[CTL_HALF_BIT];
    end
    if (start)          busy_d = 1'b1;
    else if (last_tick) busy_d = 1'b0;
    if (last_tick)               done_d = 1'b1;
    else if (start || res_rd)    done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q     <= '0;
      clksel_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ch_q     <= ch_d;
      clksel_q <= clksel_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
      irq_q    <= last_tick;
    end
  end

  sar_ce_gen u_ce (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q),
    .half_rate(clksel_q), .ce(ce)
  );

  sar_timeline #(.TOTAL(TOTAL), .SAMPLE(SAMPLE), .RES_W(RES_W)) u_tl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q), .ce(ce),
    .in_sample(in_sample), .in_decide(in_decide), .dec_bit(dec_bit),
    .last_tick(last_tick)
  );

  sar_decide #(.RES_W(RES_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .start(start), .ce(ce),
    .in_decide(in_decide), .dec_bit(dec_bit), .last_tick(last_tick),
    .cmp_in(cmp_in), .trial_code(trial_code), .result(result)
  );

  assign chan_sel  = ch_q;
  assign sample_en = in_sample;
  assign busy      = busy_q;
  assign done      = done_q;
  assign irq       = irq_q;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_W = 8,
  parameter int N_CH  = 6,
  parameter int TOTAL = 26
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [$clog2(N_CH)-1:0] chan_sel,
  input logic                    sample_en,
  input logic [RES_W-1:0]        trial_code,
  input logic [RES_W-1:0]        result,
  input logic                    busy,
  input logic                    done,
  input logic                    irq,
  input logic                    clksel_q
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == (clksel_q ? 16'(2*TOTAL) : 16'(TOTAL))));
  assert_sample_idle_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (busy && trial_code == '0));
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(result));
  assert_irq_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && $fell(busy)));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_chan_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));
  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sel <= ($clog2(N_CH))'(N_CH - 1));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES_W(RES_W), .N_CH(N_CH), .TOTAL(TOTAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .sample_en(sample_en),
  .trial_code(trial_code), .result(result), .busy(busy), .done(done),
  .irq(irq), .clksel_q(clksel_q)
);

// File: tb/sar_adc_seq_tb_top.sv
module sar_adc_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       res_rd = 1'b0;
  logic       cmp_in;
  logic [2:0] chan_sel;
  logic       sample_en;
  logic [7:0] trial_code, result;
  logic       busy, done, irq;
  logic [7:0] vin [6];

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign cmp_in = (chan_sel < 3'd6) ? (vin[chan_sel] >= trial_code) : 1'b0;

  sar_adc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .res_rd(res_rd), .cmp_in(cmp_in), .chan_sel(chan_sel),
    .sample_en(sample_en), .trial_code(trial_code), .result(result),
    .busy(busy), .done(done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion; disturb issues a write with a different setup mid-run (R7)
  task automatic convert(input logic [2:0] ch, input bit half, input int exp_ch,
                         input int expv, input bit disturb);
    int n_busy = 0;
    int n_samp = 0;
    int n_irq = 0;
    logic [7:0] prev;
    prev = result;
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = {1'b1, half, 3'b000, ch};
    @(negedge clk);
    ctl_wr = 1'b0;
    check(done == 1'b0, "R9 start clears done", done, 0);
    check(chan_sel == 3'(exp_ch), "R2 channel load", chan_sel, exp_ch);
    while (busy && n_busy < 200) begin
      n_busy++;
      if (sample_en) begin
        n_samp++;
        if (trial_code != 8'h00) check(0, "R4 trial zero in sample", trial_code, 0);
        if (n_samp != n_busy) check(0, "R4 sample window position", n_busy, n_samp);
      end
      if (irq) n_irq++;
      if (result != prev) check(0, "R6 result held", result, prev);
      if (chan_sel != 3'(exp_ch)) check(0, "R10 channel held", chan_sel, exp_ch);
      if (disturb && n_busy == 9) begin
        ctl_wr = 1'b1;
        ctl_wdata = {1'b1, ~half, 3'b000, 3'(5 - exp_ch)};
      end else begin
        ctl_wr = 1'b0;
      end
      @(negedge clk);
    end
    ctl_wr = 1'b0;
    check(n_busy == (half ? 52 : 26), "R3 busy length", n_busy, half ? 52 : 26);
    check(n_samp == (half ? 12 : 6), "R4 sample length", n_samp, half ? 12 : 6);
    check(result == 8'(expv), "R5 result code", result, expv);
    check(done && irq && n_irq == 0, "R8 done and irq at end", {done, irq}, 3);
    @(negedge clk);
    check(!irq && done, "R8 irq single cycle", {done, irq}, 2);
    if (disturb) check(chan_sel == 3'(exp_ch), "R7 write while busy ignored", chan_sel, exp_ch);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) vin[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !done && !irq && result == 0 && chan_sel == 0 && !sample_en,
          "R1 reset state", {busy, done, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && result == 0, "R1 after release", {busy, done}, 0);

    // R5 sweep of every code at full rate, channels rotated
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 6; i++) vin[i] = 8'(255 - v);
      vin[v % 6] = 8'(v);
      convert(3'(v % 6), 1'b0, v % 6, v, 1'b0);
    end
    // half-rate sweep over a spread of codes
    for (int v = 0; v < 256; v += 17) begin
      for (int i = 0; i < 6; i++) vin[i] = 8'(v ^ 8'h5A);
      vin[(v + 1) % 6] = 8'(v);
      convert(3'((v + 1) % 6), 1'b1, (v + 1) % 6, v, 1'b0);
    end
    // R2 channel codes 6 and 7 saturate to 5
    vin[5] = 8'hC3;
    convert(3'd7, 1'b0, 5, 8'hC3, 1'b0);
    convert(3'd6, 1'b1, 5, 8'hC3, 1'b0);
    // R7 writes during a conversion are ignored
    vin[1] = 8'h81;
    vin[4] = 8'h11;
    convert(3'd1, 1'b0, 1, 8'h81, 1'b1);
    convert(3'd1, 1'b1, 1, 8'h81, 1'b1);
    // R9 host read clears done, result unchanged
    @(negedge clk);
    res_rd = 1'b1;
    @(negedge clk);
    res_rd = 1'b0;
    check(done == 1'b0, "R9 read clears done", done, 0);
    check(result == 8'h81, "R9 read keeps result", result, 8'h81);
    // R2 idle write without start only reconfigures
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = 8'h03;
    @(negedge clk);
    ctl_wr = 1'b0;
    check(!busy && chan_sel == 3'd3, "R2 write without start", {busy, chan_sel}, 3);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule